// File: doc/BRIEF.md
# Bartlett FIR and Decimation Filter

This block smooths a stream of signed 16-bit samples that arrive one per `in_valid` pulse. Two equal running-sum stages of 2^B taps in cascade give a triangular (Bartlett) impulse response. A final stage sums 2^D consecutive filtered values and releases one result per 2^D filtered samples. Each result is a 32-bit fixed-point average. The upper word carries the integer part at the input scale. The lower word carries the fractional bits that averaging adds.

A change to either configuration field flushes the filter. The block then waits until its delay lines hold a full window of new samples before any result is produced. The `restart` input realigns the decimation window without touching the FIR history, so the host can line up output windows with external events.

Top module: `bartlett_decim`

## Requirements
- R1: After reset `out_valid` is 0 and `out_hi` and `out_lo` are 0.
- R2: Each running-sum stage is 2^B taps long, where B is `cfg_b`. A `cfg_b` value above 6 behaves exactly as 6.
- R3: Each filtered value is floor(S / 2^(2B)). S is the sum over the most recent 2^(B+1)−1 samples, with the sample k positions back weighted by 2^B − |k − (2^B − 1)| (newest k = 0).
- R4: The decimation stage adds 2^D consecutive filtered values, where D is `cfg_d`, and produces one result per 2^D filtered values. A `cfg_d` value above 16 behaves exactly as 16.
- R5: A result is W shifted left by 16−D, taken as a 32-bit two's-complement word, where W is the window sum. `out_hi` is bits 31:16 and `out_lo` is bits 15:0. The integer LSB weight is unchanged at every D, and the low 16−D bits of `out_lo` are 0.
- R6: With B = 0 and D = 0, every input sample appears on `out_hi` one cycle later, with `out_lo` = 0.
- R7: `out_valid` is a one-cycle pulse in the cycle after the `in_valid` cycle that completes a window. Outputs hold their value between pulses.
- R8: A cycle in which `cfg_b` or `cfg_d` differs from its previous value flushes the filter. Any sample in that cycle is dropped. No result appears until 2^(B+1)−1 new samples have arrived, and the first decimation window starts with the first full filtered value.
- R9: `restart` discards the partial decimation window. A sample accepted in the same cycle becomes the first of a new window, and the FIR history is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| cfg_b | input | 3 | Running-sum length exponent |
| cfg_d | input | 5 | Decimation exponent |
| restart | input | 1 | Restart the decimation window |
| out_valid | output | 1 | Result strobe |
| out_hi | output | 16 | Integer part of the averaged result |
| out_lo | output | 16 | Fractional bits of the averaged result, MSB-justified |

## Verification
A result is due exactly one clock after the rising edge that accepts the sample completing its window. The input is driven on a falling edge, and the bench checks `out_valid` and both words on the next falling edge, one clock later. The bench checks every accepted sample, so a pulse that is missing or comes at the wrong point is caught in that same cycle. Idle cycles and configuration-change cycles are checked one falling edge later, to confirm that no pulse occurs and that the outputs hold.

// File: rtl/bartlett_decim.sv
module bartlett_decim #(
  parameter int DW   = 16,
  parameter int BW   = 3,
  parameter int DBW  = 5,
  parameter int BMAX = 6,
  parameter int DMAX = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic [BW-1:0]        cfg_b,
  input  logic [DBW-1:0]       cfg_d,
  input  logic                 restart,
  output logic                 out_valid,
  output logic [DW-1:0]        out_hi,
  output logic [DW-1:0]        out_lo
);
  localparam int DEPTH = 1 << BMAX;
  localparam int S1W   = DW + BMAX;
  localparam int S2W   = DW + 2 * BMAX;
  localparam int AW    = DW + DMAX;
  localparam int OW    = 2 * DW;
  localparam int FW    = BMAX + 1;
  localparam int PW    = DMAX + 1;
  localparam int IW    = BMAX;

  logic [BW-1:0]  b_raw, b_eff;
  logic [DBW-1:0] d_raw, d_eff;
  logic           cfg_chg;

  assign b_eff   = (b_raw > BW'(BMAX))  ? BW'(BMAX)  : b_raw;
  assign d_eff   = (d_raw > DBW'(DMAX)) ? DBW'(DMAX) : d_raw;
  assign cfg_chg = (cfg_b != b_raw) || (cfg_d != d_raw);

  logic signed [DW-1:0]  dl1 [DEPTH];
  logic signed [S1W-1:0] dl2 [DEPTH];
  logic signed [S1W-1:0] sum1, s1_nx;
  logic signed [S2W-1:0] sum2, s2_nx, s2_sh;
  logic signed [DW-1:0]  filt;
  logic [IW-1:0]         tap;

  assign tap   = IW'((32'd1 << b_eff) - 32'd1);
  assign s1_nx = sum1 + S1W'(in_data) - S1W'(dl1[tap]);
  assign s2_nx = sum2 + S2W'(s1_nx) - S2W'(dl2[tap]);
  assign s2_sh = s2_nx >>> {b_eff, 1'b0};
  assign filt  = DW'(s2_sh);

  logic [FW-1:0] fill_cnt;
  logic          full;
  assign full = fill_cnt >= FW'((32'd2 << b_eff) - 32'd2);

  logic [PW-1:0]        ph, ph_cur;
  logic signed [AW-1:0] acc, acc_base, acc_nx;
  logic                 last;
  logic [OW-1:0]        out_w;

  assign ph_cur   = restart ? '0 : ph;
  assign acc_base = (ph_cur == '0) ? '0 : acc;
  assign acc_nx   = acc_base + AW'(filt);
  assign last     = ph_cur == PW'((33'd1 << d_eff) - 33'd1);
  assign out_w    = OW'(acc_nx) << (DW - int'(d_eff));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_raw     <= '0;
      d_raw     <= '0;
      sum1      <= '0;
      sum2      <= '0;
      fill_cnt  <= '0;
      ph        <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_hi    <= '0;
      out_lo    <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        dl1[i] <= '0;
        dl2[i] <= '0;
      end
    end else begin
      out_valid <= 1'b0;
      if (cfg_chg) begin
        b_raw    <= cfg_b;
        d_raw    <= cfg_d;
        sum1     <= '0;
        sum2     <= '0;
        fill_cnt <= '0;
        ph       <= '0;
        acc      <= '0;
        for (int i = 0; i < DEPTH; i++) begin
          dl1[i] <= '0;
          dl2[i] <= '0;
        end
      end else begin
        if (restart) ph <= '0;
        if (in_valid) begin
          dl1[0] <= in_data;
          dl2[0] <= s1_nx;
          for (int i = 1; i < DEPTH; i++) begin
            dl1[i] <= dl1[i-1];
            dl2[i] <= dl2[i-1];
          end
          sum1 <= s1_nx;
          sum2 <= s2_nx;
          if (fill_cnt != '1) fill_cnt <= fill_cnt + 1'b1;
          if (full) begin
            acc <= acc_nx;
            ph  <= last ? '0 : ph_cur + 1'b1;
            if (last) begin
              out_valid <= 1'b1;
              out_hi    <= out_w[OW-1:DW];
              out_lo    <= out_w[DW-1:0];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/bartlett_decim_chk.sv
module bartlett_decim_chk #(
  parameter int DW  = 16,
  parameter int BW  = 3,
  parameter int DBW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [DW-1:0]  in_data,
  input logic [BW-1:0]  cfg_b,
  input logic [DBW-1:0] cfg_d,
  input logic           restart,
  input logic           out_valid,
  input logic [DW-1:0]  out_hi,
  input logic [DW-1:0]  out_lo,
  input logic [BW-1:0]  b_raw,
  input logic [DBW-1:0] d_raw,
  input logic [DBW-1:0] d_eff
);
  assert_pulse_follows_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  assert_passthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_b == '0 && cfg_d == '0 && b_raw == '0 && d_raw == '0)
    |=> (out_valid && out_hi == $past(in_data) && out_lo == '0));

  assert_lo_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((2*DW)'(out_lo) << d_eff) & {{DW{1'b0}}, {DW{1'b1}}}) == '0);

  assert_flush_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ({cfg_b, cfg_d} != {b_raw, d_raw}) |=> !out_valid);

  assert_restart_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && d_eff != '0 && cfg_b == b_raw && cfg_d == d_raw) |=> !out_valid);
endmodule

bind bartlett_decim bartlett_decim_chk #(.DW(DW), .BW(BW), .DBW(DBW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .cfg_b(cfg_b), .cfg_d(cfg_d), .restart(restart),
  .out_valid(out_valid), .out_hi(out_hi), .out_lo(out_lo),
  .b_raw(b_raw), .d_raw(d_raw), .d_eff(d_eff)
);

// File: tb/tb_bartlett_decim.sv
module tb_bartlett_decim;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic [2:0]  cfg_b = '0;
  logic [4:0]  cfg_d = '0;
  logic        restart = 1'b0;
  logic        out_valid;
  logic [15:0] out_hi, out_lo;

  int nchk = 0, nfail = 0;
  bit done = 0;

  int     hist[$];
  int     m_b = 0, m_d = 0, nfill = 0, mph = 0;
  longint macc = 0;
  logic [15:0] last_hi = '0, last_lo = '0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  bartlett_decim dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cfg_b(cfg_b), .cfg_d(cfg_d), .restart(restart),
    .out_valid(out_valid), .out_hi(out_hi), .out_lo(out_lo)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rnd(input int span);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed >> 8) % (2 * span + 1) - span;
  endfunction

  task automatic set_cfg(input int b, input int d);
    cfg_b = 3'(b);
    cfg_d = 5'(d);
    @(negedge clk);
    m_b = (b > 6) ? 6 : b;
    m_d = (d > 16) ? 16 : d;
    hist.delete();
    nfill = 0; mph = 0; macc = 0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 no pulse on config change", out_valid, 0);
  endtask

  task automatic drive(input int x, input bit rs, input string req);
    int n;
    longint s, f;
    logic [31:0] e;
    bit exp_v;
    in_valid = 1'b1; in_data = 16'(x); restart = rs;
    @(negedge clk);
    in_valid = 1'b0; restart = 1'b0;
    n = 1 << m_b;
    hist.push_front(x);
    if (hist.size() > 128) void'(hist.pop_back());
    nfill++;
    if (rs) mph = 0;
    exp_v = 0;
    if (nfill >= 2 * n - 1) begin
      s = 0;
      for (int k = 0; k <= 2 * n - 2; k++) begin
        int w;
        w = (k < n) ? k + 1 : 2 * n - 1 - k;
        s += longint'(w) * hist[k];
      end
      f = s >>> (2 * m_b);
      if (mph == 0) macc = 0;
      macc += f;
      if (mph == (1 << m_d) - 1) begin
        exp_v = 1;
        mph = 0;
        e = 32'(macc <<< (16 - m_d));
        last_hi = e[31:16];
        last_lo = e[15:0];
      end else mph++;
    end
    chk(out_valid == exp_v, {req, " out_valid"}, out_valid, exp_v);
    if (exp_v) begin
      chk(out_hi == last_hi, {req, " out_hi"}, out_hi, last_hi);
      chk(out_lo == last_lo, {req, " out_lo"}, out_lo, last_lo);
    end
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    chk(out_valid == 1'b0, {req, " idle pulse"}, out_valid, 0);
    chk(out_hi == last_hi && out_lo == last_lo, {req, " outputs hold"}, {out_hi, out_lo}, {last_hi, last_lo});
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(out_hi == 16'h0, "R1 out_hi", out_hi, 0);
    chk(out_lo == 16'h0, "R1 out_lo", out_lo, 0);
  endtask

  task automatic t_passthrough;
    set_cfg(0, 0);
    drive(5, 0, "R6");
    drive(-32768, 0, "R6");
    drive(32767, 0, "R6");
    drive(-1, 0, "R6");
    idle_check("R7");
    for (int i = 0; i < 10; i++) drive(rnd(30000), 0, "R6");
  endtask

  task automatic t_triangle;
    set_cfg(2, 0);
    for (int i = 0; i < 30; i++) drive(rnd(20000), 0, "R3");
    idle_check("R7");
  endtask

  task automatic t_decim;
    set_cfg(0, 3);
    for (int i = 0; i < 40; i++) drive(rnd(50), 0, "R4 R5");
  endtask

  task automatic t_mixed;
    set_cfg(3, 2);
    for (int i = 0; i < 60; i++) drive(rnd(32000), 0, "R3 R4 R5");
  endtask

  task automatic t_bclamp;
    set_cfg(7, 0);
    for (int i = 0; i < 140; i++) drive(rnd(30000), 0, "R2 clamp");
  endtask

  task automatic t_restart;
    set_cfg(1, 2);
    for (int i = 0; i < 6; i++) drive(rnd(1000), 0, "R9");
    drive(rnd(1000), 1, "R9 restart with sample");
    for (int i = 0; i < 5; i++) drive(rnd(1000), 0, "R9");
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    mph = 0;
    for (int i = 0; i < 9; i++) drive(rnd(1000), 0, "R9 restart idle");
  endtask

  task automatic t_change;
    set_cfg(1, 1);
    for (int i = 0; i < 9; i++) drive(rnd(4000), 0, "R8");
    set_cfg(2, 1);
    for (int i = 0; i < 12; i++) drive(rnd(4000), 0, "R8 refill");
  endtask

  task automatic t_dclamp;
    set_cfg(0, 31);
    for (int i = 0; i < 65536; i++) drive(1000 + (i & 1), 0, "R4 R5 dmax");
    chk(last_hi == 16'd1000 && last_lo == 16'h8000, "R5 dmax result",
        {last_hi, last_lo}, {16'd1000, 16'h8000});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_passthrough();
    t_triangle();
    t_decim();
    t_mixed();
    t_bclamp();
    t_restart();
    t_change();
    t_dclamp();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule